// File: doc/BRIEF.md
# Segment Access Rights Checker

This block decides whether a single memory access may proceed under the rights carried in a segment's 8-bit attribute byte. It is given that byte, the privilege level of the running code, the privilege level requested by the selector, and the kind of access: an instruction fetch, a data read or a data write. It answers with an allow flag and a violation class that says why an access was refused.

The attribute byte holds a present flag, a two-bit descriptor privilege level, a flag that separates system descriptors from code/data descriptors, and a four-bit type field. The type field's meaning changes with its top bit. For data segments, bit 1 enables writes and bit 2 marks expand-down. For code segments, bit 1 enables reads and bit 2 marks the segment conforming. Reads from data and fetches from code are implicit. Code can never be written. The privilege rule is chosen by segment kind: data compares the larger of the two caller levels against the descriptor level, non-conforming code needs an exact match, and conforming code accepts equal or less privileged callers.

The decision is registered: the verdict for the inputs present at a rising clock edge appears on the outputs after that edge and holds until the next one. The block is meant to sit in an address-translation pipeline next to a limit check.

Top module: `seg_access_check`

## Requirements
- R1: While reset is high, and at the first edge after it, the outputs settle to allow=0 and class=0 (no violation).
- R2: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R3: With attribute bit 7 (present) at 0, the class is 1 (absent) and allow is 0, whatever the other inputs are.
- R4: With the segment present and bit 4 at 0 (system descriptor), the class is 2 (system) for every access kind.
- R5: Data segments (bit 3 = 0): a read (kind 1) always passes the type check, a write (kind 2) passes only with bit 1 set, and a fetch (kind 0) is refused with class 3 (type). Bit 2 and bit 0 have no effect.
- R6: Code segments (bit 3 = 1): a fetch always passes the type check, a read passes only with bit 1 set, and a write is always refused with class 3. Bit 0 has no effect.
- R7: Access kind 3 is invalid and is refused with class 3 for any present code/data segment.
- R8: For data segments that pass the type check, the access is allowed only when max(CPL, RPL) is at most the DPL (bits 6:5); otherwise the class is 4 (privilege).
- R9: For non-conforming code (bit 2 = 0), the privilege check passes only when CPL equals the DPL, whatever the RPL is.
- R10: For conforming code (bit 2 = 1), the privilege check passes when CPL is greater than or equal to the DPL, whatever the RPL is.
- R11: Classes are reported in priority order absent, system, type, privilege, and allow is 1 exactly when the class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| attr_i | input | 8 | Segment attribute byte (present, DPL, code/data flag, type) |
| cpl_i | input | 2 | Privilege level of the running code |
| rpl_i | input | 2 | Requested privilege level from the selector |
| kind_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 invalid |
| allow_o | output | 1 | Registered verdict, 1 when the access may proceed |
| violation_o | output | 3 | Registered class: 0 none, 1 absent, 2 system, 3 type, 4 privilege |

## Verification
The only internal state is the output register pair, so a wrong decode appears as a wrong class on the cycle right after the inputs are sampled and does not persist. The sweep covers every combination of attribute byte, both privilege levels and access kind. Any mis-wired type bit, swapped comparison or broken priority is therefore seen at the ports within one clock of the first input pattern that exposes it. Directed steps check the reset values and that an output holds still between edges.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    VIOL_NONE   = 3'd0,
    VIOL_ABSENT = 3'd1,
    VIOL_SYSTEM = 3'd2,
    VIOL_TYPE   = 3'd3,
    VIOL_PRIV   = 3'd4
  } viol_e;

  localparam int TYPE_W = 4;
endpackage

// File: rtl/segchk_type_rules.sv
module segchk_type_rules
  import segchk_pkg::*;
(
  input  logic       is_code_i,
  input  logic       opt_bit_i,
  input  logic [1:0] kind_i,
  output logic       type_ok_o
);
  // bit 1 means "writable" for data and "readable" for code
  always_comb begin
    case (acc_kind_e'(kind_i))
      KIND_FETCH: type_ok_o = is_code_i;
      KIND_READ:  type_ok_o = !is_code_i || opt_bit_i;
      KIND_WRITE: type_ok_o = !is_code_i && opt_bit_i;
      default:    type_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/segchk_priv_rules.sv
module segchk_priv_rules #(
  parameter int PRIV_W = 2
) (
  input  logic              is_code_i,
  input  logic              conforming_i,
  input  logic [PRIV_W-1:0] cpl_i,
  input  logic [PRIV_W-1:0] rpl_i,
  input  logic [PRIV_W-1:0] dpl_i,
  output logic              priv_ok_o
);
  logic [PRIV_W-1:0] eff_lvl;

  always_comb begin
    eff_lvl = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    if (!is_code_i)
      priv_ok_o = (eff_lvl <= dpl_i);
    else if (conforming_i)
      priv_ok_o = (cpl_i >= dpl_i);
    else
      priv_ok_o = (cpl_i == dpl_i);
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import segchk_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIV_W+5:0] attr_i,
  input  logic [PRIV_W-1:0] cpl_i,
  input  logic [PRIV_W-1:0] rpl_i,
  input  logic [1:0]        kind_i,
  output logic              allow_o,
  output logic [2:0]        violation_o
);
  localparam int CD_POS   = TYPE_W;          // code/data descriptor flag
  localparam int DPL_LO   = CD_POS + 1;
  localparam int PRES_POS = DPL_LO + PRIV_W;
  localparam int EXEC_POS = TYPE_W - 1;
  localparam int CONF_POS = TYPE_W - 2;
  localparam int OPT_POS  = TYPE_W - 3;

  logic              present, code_data, is_code;
  logic [PRIV_W-1:0] dpl;
  logic              type_ok, priv_ok;
  viol_e             viol_d;

  assign present   = attr_i[PRES_POS];
  assign code_data = attr_i[CD_POS];
  assign is_code   = attr_i[EXEC_POS];
  assign dpl       = attr_i[DPL_LO +: PRIV_W];

  segchk_type_rules u_type (
    .is_code_i (is_code),
    .opt_bit_i (attr_i[OPT_POS]),
    .kind_i    (kind_i),
    .type_ok_o (type_ok)
  );

  segchk_priv_rules #(.PRIV_W(PRIV_W)) u_priv (
    .is_code_i    (is_code),
    .conforming_i (attr_i[CONF_POS]),
    .cpl_i        (cpl_i),
    .rpl_i        (rpl_i),
    .dpl_i        (dpl),
    .priv_ok_o    (priv_ok)
  );

  always_comb begin
    if (!present)        viol_d = VIOL_ABSENT;
    else if (!code_data) viol_d = VIOL_SYSTEM;
    else if (!type_ok)   viol_d = VIOL_TYPE;
    else if (!priv_ok)   viol_d = VIOL_PRIV;
    else                 viol_d = VIOL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_o     <= 1'b0;
      violation_o <= VIOL_NONE;
    end else begin
      allow_o     <= (viol_d == VIOL_NONE);
      violation_o <= viol_d;
    end
  end
endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva #(
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [PRIV_W+5:0] attr_i,
  input logic [PRIV_W-1:0] cpl_i,
  input logic [PRIV_W-1:0] rpl_i,
  input logic [1:0]        kind_i,
  input logic              allow_o,
  input logic [2:0]        violation_o
);
  localparam int PRES_POS = PRIV_W + 5;
  localparam int DPL_LO   = 5;

  assert_absent_R3: assert property (@(posedge clk) disable iff (rst)
    !attr_i[PRES_POS] |=> (violation_o == 3'd1 && !allow_o));

  assert_system_R4: assert property (@(posedge clk) disable iff (rst)
    (attr_i[PRES_POS] && !attr_i[4]) |=> (violation_o == 3'd2));

  assert_code_write_R6: assert property (@(posedge clk) disable iff (rst)
    (attr_i[PRES_POS] && attr_i[4] && attr_i[3] && kind_i == 2'd2) |=> (violation_o == 3'd3));

  assert_bad_kind_R7: assert property (@(posedge clk) disable iff (rst)
    (attr_i[PRES_POS] && attr_i[4] && kind_i == 2'd3) |=> (violation_o == 3'd3));

  assert_exact_match_R9: assert property (@(posedge clk) disable iff (rst)
    (attr_i[PRES_POS] && attr_i[4] && attr_i[3] && !attr_i[2] &&
     cpl_i != attr_i[DPL_LO +: PRIV_W]) |=> !allow_o);

  assert_allow_class_R11: assert property (@(posedge clk) disable iff (rst)
    allow_o |-> (violation_o == 3'd0));
endmodule

bind seg_access_check seg_access_check_sva #(.PRIV_W(PRIV_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .attr_i      (attr_i),
  .cpl_i       (cpl_i),
  .rpl_i       (rpl_i),
  .kind_i      (kind_i),
  .allow_o     (allow_o),
  .violation_o (violation_o)
);

// File: tb/seg_access_check_bench.sv
`timescale 1ns/1ps
module seg_access_check_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] attr = 8'h00;
  logic [1:0] cpl = 2'd0, rpl = 2'd0, kind = 2'd0;
  logic       allow_o;
  logic [2:0] violation_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_access_check u_seg_access_check (
    .clk (clk), .rst (rst), .attr_i (attr), .cpl_i (cpl), .rpl_i (rpl),
    .kind_i (kind), .allow_o (allow_o), .violation_o (violation_o)
  );

  task automatic chk(input string tag, input logic ea, input logic [2:0] ev);
    n_chk++;
    if (allow_o !== ea || violation_o !== ev) begin
      n_fail++;
      $display("FAIL %s attr=%02h cpl=%0d rpl=%0d kind=%0d: got allow=%0b class=%0d, expected allow=%0b class=%0d",
               tag, attr, cpl, rpl, kind, allow_o, violation_o, ea, ev);
    end
  endtask

  // expected verdict computed from the requirement text
  task automatic expect_of(input int a, input int c, input int r, input int k,
                           output int cls, output string tag);
    int p, s, code, b2, b1, dpl, eff;
    bit tok, pok;
    p = (a >> 7) & 1; dpl = (a >> 5) & 3; s = (a >> 4) & 1;
    code = (a >> 3) & 1; b2 = (a >> 2) & 1; b1 = (a >> 1) & 1;
    eff = (c > r) ? c : r;
    if (k == 0)      tok = (code == 1);
    else if (k == 1) tok = (code == 0) || (b1 == 1);
    else if (k == 2) tok = (code == 0) && (b1 == 1);
    else             tok = 0;
    if (code == 0)    pok = (eff <= dpl);
    else if (b2 == 1) pok = (c >= dpl);
    else              pok = (c == dpl);
    if (p == 0)      begin cls = 1; tag = "R3"; end
    else if (s == 0) begin cls = 2; tag = "R4"; end
    else if (k == 3) begin cls = 3; tag = "R7"; end
    else if (!tok)   begin cls = 3; tag = code ? "R6" : "R5"; end
    else begin
      cls = pok ? 0 : 4;
      if (code == 0)    tag = "R8";
      else if (b2 == 1) tag = "R10";
      else              tag = "R9";
    end
  endtask

  initial begin
    int cls;
    string tag;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", 1'b0, 3'd0);
    @(negedge clk);
    attr = 8'h92; kind = 2'd1;   // present data read, would be allowed
    rst = 1'b0;
    @(posedge clk); #1 chk("R1 first edge", 1'b1, 3'd0);

    // R2: a change between edges does not reach the outputs
    @(negedge clk); attr = 8'h12;
    #1 chk("R2 hold", 1'b1, 3'd0);
    @(posedge clk); #1 chk("R2 update", 1'b0, 3'd1);

    // R11: type outranks privilege (write to read-only data, DPL 0, CPL 3)
    @(negedge clk); attr = 8'h90; cpl = 2'd3; rpl = 2'd3; kind = 2'd2;
    @(posedge clk); #1 chk("R11 type before priv", 1'b0, 3'd3);

    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            attr = 8'(a); cpl = 2'(c); rpl = 2'(r); kind = 2'(k);
            expect_of(a, c, r, k, cls, tag);
            @(posedge clk); #1;
            chk(tag, (cls == 0), 3'(cls));
          end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule